// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Queue

This block turns an asynchronous serial line into a queue of received characters. An oversampling enable, pulsed once for every sixteenth of a bit period by logic outside the block, paces a sampling state machine. The machine checks the start bit at mid-bit, collects 5 to 8 data bits least significant first, and can check a parity bit. It then tests the stop bit. Each finished character enters a 16-entry first-word-fall-through queue as a 12-bit word. The word holds the data, three error flags for that character, and a flag that reports that an earlier character was lost.

The serial input passes through a two-stage synchronizer before any decision is made on it. An all-low frame counts as a line break. After a break the receiver stays idle until the line has gone high again. A flow-control output, active low, tells the far end when the queue has filled to a programmable mark. The consumer reads entries through a simple valid/read-enable pair and can see the current fill count.

Top module: `async_rx_core`

## Requirements
- R1: After reset the queue is empty: `level` is 0 and `rd_valid` is 0.
- R2: A falling edge on the synchronized line starts a count of `tick16` pulses, and the line is sampled again on the 8th pulse. If the line is high at that point the event is dropped and no entry is written.
- R3: After a confirmed start, one data bit is sampled every 16 `tick16` pulses, least significant bit first. There are 5, 6, 7 or 8 data bits for `cfg_len` = 0, 1, 2, 3. The character sits right-aligned in entry bits 7:0, and the unused upper bits are zero.
- R4: With `cfg_par_en` = 1, one parity bit follows the data. The expected value is the XOR of the data bits when `cfg_par_even` = 1 and its inverse when `cfg_par_even` = 0. With `cfg_par_stick` = 1 the expected value is the constant `~cfg_par_even`. A mismatch sets entry bit 9.
- R5: A stop bit sampled low sets entry bit 8.
- R6: A frame whose data bits, parity bit (if enabled) and stop bit are all low sets entry bit 10 (bit 8 is set as well). The receiver then ignores the line until it has been seen high, and a normal frame after that is received correctly.
- R7: The queue holds up to 16 entries in arrival order. When `rd_valid` is 1, `rd_data` shows the oldest entry, and `rd_en` removes it on the clock edge. `level` gives the number of entries held, and `rd_valid` is 1 exactly when `level` is not 0.
- R8: A character that completes while the queue is full is discarded, and `level` stays at 16.
- R9: After such a loss, the next character that is stored carries entry bit 11 set. Bit 11 is then cleared, and later characters carry it at 0.
- R10: With `rts_en` = 1, `rts_n` is 0 while `level` < `rts_wm` and 1 once `level` ≥ `rts_wm`. With `rts_en` = 0, `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Single-cycle enable at sixteen times the bit rate |
| rxd | input | 1 | Serial input, asynchronous, idles high |
| cfg_len | input | 2 | Data length code: 0 to 3 for 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_par_stick | input | 1 | Parity bit is the constant ~cfg_par_even |
| rts_en | input | 1 | Enables the watermark flow-control output |
| rts_wm | input | 5 | Fill level at which rts_n goes high |
| rd_en | input | 1 | Removes the oldest entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 12 | Oldest entry: {overrun, break, parity err, framing err, data[7:0]} |
| level | output | 5 | Number of entries held |
| rts_n | output | 1 | Request to send, active low |

## Verification
The checker assumes that `tick16` is a one-cycle pulse with at least a few clocks between pulses. It assumes the format inputs stay constant while a frame is in flight, and that `rts_wm` is no greater than the queue depth. The stimulus meets these conditions. It fixes `tick16` at one pulse in every four clocks, and it changes the format only on the idle line between frames. It holds every serial bit for a whole bit period of 64 clocks. Stop bits that are meant to be low are kept short, so that the line is high again before the receiver could confirm a new start.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   // Per-character error flags, packed so that {brk, par, frm} lands in entry bits 10:8.
   typedef struct packed {
      logic brk;
      logic par;
      logic frm;
   } rx_err_t;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4,
      RX_HOLD  = 3'd5
   } rx_state_e;

   localparam int unsigned FLAG_BITS = 4;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_stage_chk
         $error("async_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RESET_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/async_rx_deser.sv
module async_rx_deser
   import async_rx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int LEN_W      = 2,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              par_stick,
   output logic              chr_valid,
   output logic [DATA_W-1:0] chr_data,
   output rx_err_t           chr_err
);

   localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
   localparam int IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int NB_W    = IDX_W + 1;
   localparam logic [3:0] MID_TICK = 4'd7;
   localparam logic [3:0] END_TICK = 4'd15;

   generate
      if (MIN_LEN < 1) begin : g_len_chk
         $error("async_rx_deser: DATA_W too small for LEN_W length codes");
      end
   endgenerate

   // Parity support is optional; without it the parity state is never entered.
   logic par_use;
   generate
      if (HAS_PARITY) begin : g_par
         assign par_use = par_en;
      end else begin : g_nopar
         assign par_use = 1'b0;
      end
   endgenerate

   rx_state_e         state_q;
   logic [3:0]        tcnt_q;
   logic [IDX_W-1:0]  bidx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              acc_q;
   logic              pbit_q;

   logic [NB_W-1:0]   nbits;
   logic [IDX_W-1:0]  last_idx;
   logic [NB_W-1:0]   align;
   logic              exp_par;
   logic              is_break;

   assign nbits    = NB_W'(MIN_LEN) + NB_W'(cfg_len);
   assign last_idx = IDX_W'(nbits - 1'b1);
   assign align    = NB_W'(DATA_W) - nbits;
   assign exp_par  = par_stick ? ~par_even : (par_even ? acc_q : ~acc_q);
   assign is_break = (shreg_q == '0) && !(par_use && pbit_q) && !rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         tcnt_q    <= '0;
         bidx_q    <= '0;
         shreg_q   <= '0;
         acc_q     <= 1'b0;
         pbit_q    <= 1'b0;
         chr_valid <= 1'b0;
         chr_data  <= '0;
         chr_err   <= '0;
      end else begin
         chr_valid <= 1'b0;
         if (tick) begin
            unique case (state_q)
               RX_IDLE: begin
                  if (!rx) begin
                     state_q <= RX_START;
                     tcnt_q  <= 4'd1;
                  end
               end
               RX_START: begin
                  if (tcnt_q == MID_TICK) begin
                     tcnt_q <= '0;
                     if (!rx) begin
                        state_q <= RX_DATA;
                        bidx_q  <= '0;
                        shreg_q <= '0;
                        acc_q   <= 1'b0;
                        pbit_q  <= 1'b0;
                     end else begin
                        state_q <= RX_IDLE;
                     end
                  end else begin
                     tcnt_q <= tcnt_q + 4'd1;
                  end
               end
               RX_DATA: begin
                  if (tcnt_q == END_TICK) begin
                     tcnt_q  <= '0;
                     shreg_q <= {rx, shreg_q[DATA_W-1:1]};
                     acc_q   <= acc_q ^ rx;
                     if (bidx_q == last_idx) begin
                        state_q <= par_use ? RX_PAR : RX_STOP;
                     end else begin
                        bidx_q <= bidx_q + 1'b1;
                     end
                  end else begin
                     tcnt_q <= tcnt_q + 4'd1;
                  end
               end
               RX_PAR: begin
                  if (tcnt_q == END_TICK) begin
                     tcnt_q  <= '0;
                     pbit_q  <= rx;
                     state_q <= RX_STOP;
                  end else begin
                     tcnt_q <= tcnt_q + 4'd1;
                  end
               end
               RX_STOP: begin
                  if (tcnt_q == END_TICK) begin
                     tcnt_q      <= '0;
                     chr_valid   <= 1'b1;
                     chr_data    <= shreg_q >> align;
                     chr_err.frm <= !rx;
                     chr_err.par <= par_use && (pbit_q != exp_par);
                     chr_err.brk <= is_break;
                     state_q     <= is_break ? RX_HOLD : RX_IDLE;
                  end else begin
                     tcnt_q <= tcnt_q + 4'd1;
                  end
               end
               RX_HOLD: begin
                  if (rx) state_q <= RX_IDLE;
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
   import async_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [DATA_W-1:0]             push_data,
   input  rx_err_t                       push_err,
   input  logic                          pop,
   output logic [DATA_W+FLAG_BITS-1:0]   rd_data,
   output logic                          rd_valid,
   output logic [$clog2(DEPTH+1)-1:0]    level
);

   localparam int W     = DATA_W + FLAG_BITS;
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_depth_chk
         $error("async_rx_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [AW-1:0]    wr_q, rd_q, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] lvl_q;
   logic             ovr_q;
   logic             full, do_push, do_pop;

   // Power-of-two depths wrap for free; other depths compare against the last slot.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_free
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (lvl_q != '0);

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= {ovr_q, push_err, push_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
         if (push && full)  ovr_q <= 1'b1;
         else if (do_push)  ovr_q <= 1'b0;
      end
   end

   assign rd_data  = mem[rd_q];
   assign rd_valid = (lvl_q != '0);
   assign level    = lvl_q;

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
   import async_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int LEN_W       = 2,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PARITY  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick16,
   input  logic                         rxd,
   input  logic [LEN_W-1:0]             cfg_len,
   input  logic                         cfg_par_en,
   input  logic                         cfg_par_even,
   input  logic                         cfg_par_stick,
   input  logic                         rts_en,
   input  logic [$clog2(DEPTH+1)-1:0]   rts_wm,
   input  logic                         rd_en,
   output logic                         rd_valid,
   output logic [DATA_W+FLAG_BITS-1:0]  rd_data,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         rts_n
);

   logic              rx_s;
   logic              chr_valid;
   logic [DATA_W-1:0] chr_data;
   rx_err_t           chr_err;

   async_rx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (rx_s)
   );

   async_rx_deser #(
      .DATA_W     (DATA_W),
      .LEN_W      (LEN_W),
      .HAS_PARITY (HAS_PARITY)
   ) u_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .rx        (rx_s),
      .cfg_len   (cfg_len),
      .par_en    (cfg_par_en),
      .par_even  (cfg_par_even),
      .par_stick (cfg_par_stick),
      .chr_valid (chr_valid),
      .chr_data  (chr_data),
      .chr_err   (chr_err)
   );

   async_rx_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (chr_valid),
      .push_data (chr_data),
      .push_err  (chr_err),
      .pop       (rd_en),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .level     (level)
   );

   assign rts_n = rts_en & (level >= rts_wm);

endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker #(
   parameter int DEPTH = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rd_en,
   input logic                       rd_valid,
   input logic                       chr_valid,
   input logic                       rts_en,
   input logic                       rts_n,
   input logic [$clog2(DEPTH+1)-1:0] level,
   input logic [$clog2(DEPTH+1)-1:0] rts_wm
);

   localparam int LVL_W = $clog2(DEPTH + 1);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH)) else $error("AST_NO_OVERFLOW"); // R7

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_valid && !chr_valid) |=> (level == LVL_W'($past(level) - 1'b1)))
      else $error("AST_POP_STEP"); // R7

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid && (level < LVL_W'(DEPTH)) && !(rd_en && rd_valid)) |=> (level == LVL_W'($past(level) + 1'b1)))
      else $error("AST_PUSH_STEP"); // R7

   AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && !chr_valid) |=> (level == '0)) else $error("AST_EMPTY_STAYS"); // R7

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_valid && (level == LVL_W'(DEPTH)) && !rd_en) |=> (level == LVL_W'(DEPTH)))
      else $error("AST_FULL_DROP"); // R8

   AST_RTS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_en && (level < rts_wm)) |-> !rts_n) else $error("AST_RTS_BELOW"); // R10

   AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rts_en |-> !rts_n) else $error("AST_RTS_OFF"); // R10

endmodule

bind async_rx_core async_rx_checker #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .rd_valid  (rd_valid),
   .chr_valid (chr_valid),
   .rts_en    (rts_en),
   .rts_n     (rts_n),
   .level     (level),
   .rts_wm    (rts_wm)
);

// File: tb/async_rx_core_bench.sv
module async_rx_core_bench;

   localparam int BIT_CLKS = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick16 = 1'b0;
   logic        rxd = 1'b1;
   logic [1:0]  cfg_len = 2'd3;
   logic        cfg_par_en = 1'b0;
   logic        cfg_par_even = 1'b0;
   logic        cfg_par_stick = 1'b0;
   logic        rts_en = 1'b1;
   logic [4:0]  rts_wm = 5'd4;
   logic        rd_en = 1'b0;
   logic        rd_valid;
   logic [11:0] rd_data;
   logic [4:0]  level;
   logic        rts_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [11:0] exp_q[$];
   bit          ovr_m = 1'b0;

   always #4 clk = ~clk;

   async_rx_core u_async_rx_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick16        (tick16),
      .rxd           (rxd),
      .cfg_len       (cfg_len),
      .cfg_par_en    (cfg_par_en),
      .cfg_par_even  (cfg_par_even),
      .cfg_par_stick (cfg_par_stick),
      .rts_en        (rts_en),
      .rts_wm        (rts_wm),
      .rd_en         (rd_en),
      .rd_valid      (rd_valid),
      .rd_data       (rd_data),
      .level         (level),
      .rts_n         (rts_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Oversampling enable: one pulse in every four clocks.
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         tick16 = (div == 3);
         div = (div + 1) % 4;
      end
   end

   // Per-clock comparison against the behavioural rules for flow control and validity.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && !done) begin
            check(rts_n == (rts_en && (level >= rts_wm)), "R10 rts_n per clock", rts_n, rts_en && (level >= rts_wm));
            check(rd_valid == (level != 0), "R7 rd_valid vs level", rd_valid, level != 0);
         end
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic drive(input logic b, input int n);
      rxd = b;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input int len, input bit pen, input bit even,
                             input bit stick, input bit bad_par, input bit stop, input int stop_clks);
      logic [7:0]  dm;
      logic        p;
      logic [11:0] e;
      dm = '0;
      for (int i = 0; i < len; i++) dm[i] = d[i];
      p = stick ? ~even : (even ? ^dm : ~^dm);
      if (bad_par) p = ~p;
      cfg_len       = 2'(len - 5);
      cfg_par_en    = pen;
      cfg_par_even  = even;
      cfg_par_stick = stick;
      drive(1'b0, BIT_CLKS);
      for (int i = 0; i < len; i++) drive(dm[i], BIT_CLKS);
      if (pen) drive(p, BIT_CLKS);
      drive(stop, stop_clks);
      drive(1'b1, BIT_CLKS);
      e = {1'b0, (dm == 8'd0) && (!pen || !p) && !stop, pen && bad_par, !stop, dm};
      if (exp_q.size() == 16) begin
         ovr_m = 1'b1;
      end else begin
         e[11] = ovr_m;
         exp_q.push_back(e);
         ovr_m = 1'b0;
      end
   endtask

   task automatic pop_check(input string tag);
      logic [11:0] e;
      if (exp_q.size() == 0) begin
         check(1'b0, {tag, " model empty"}, 0, 1);
         return;
      end
      e = exp_q.pop_front();
      check(rd_valid == 1'b1, {tag, " rd_valid"}, rd_valid, 1);
      check(rd_data == e, {tag, " entry"}, rd_data, e);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic level_check(input string tag);
      check(level == 5'(exp_q.size()), tag, level, exp_q.size());
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(level == 0, "R1 level after reset", level, 0);
      check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
      check(rts_n == 1'b0, "R10 rts_n low when empty", rts_n, 0);

      // R3: 8 data bits, no parity
      send_frame(8'hA5, 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      level_check("R7 level after one frame");
      pop_check("R3 8-bit A5");

      // R3: 5-bit character, upper bits zero
      send_frame(8'hF6, 5, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      pop_check("R3 5-bit zero extend");
      send_frame(8'h5B, 6, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      pop_check("R3 6-bit");

      // R4: parity modes, good and bad
      send_frame(8'h35, 7, 1, 1, 0, 0, 1'b1, BIT_CLKS);
      send_frame(8'h35, 7, 1, 1, 0, 1, 1'b1, BIT_CLKS);
      send_frame(8'hC3, 8, 1, 0, 0, 0, 1'b1, BIT_CLKS);
      send_frame(8'hC3, 8, 1, 0, 0, 1, 1'b1, BIT_CLKS);
      send_frame(8'h96, 8, 1, 1, 1, 0, 1'b1, BIT_CLKS);
      send_frame(8'h96, 8, 1, 0, 1, 1, 1'b1, BIT_CLKS);
      level_check("R7 level after six frames");
      check(rts_n == 1'b1, "R10 rts_n high at watermark", rts_n, 1);
      pop_check("R4 even good");
      pop_check("R4 even bad");
      pop_check("R4 odd good");
      pop_check("R4 odd bad");
      pop_check("R4 stick zero good");
      pop_check("R4 stick one bad");

      // R5: framing error, short low stop
      send_frame(8'h3C, 8, 0, 0, 0, 0, 1'b0, 40);
      level_check("R5 single framing entry");
      pop_check("R5 framing flag");

      // R6: break, long low, then a normal frame
      send_frame(8'h00, 8, 0, 0, 0, 0, 1'b0, BIT_CLKS * 6);
      send_frame(8'h81, 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      level_check("R6 break plus next frame");
      pop_check("R6 break flags");
      pop_check("R6 frame after break");

      // R2: false start
      drive(1'b0, 12);
      drive(1'b1, BIT_CLKS * 3);
      check(level == 0, "R2 false start ignored", level, 0);
      send_frame(8'h5A, 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      pop_check("R2 frame after false start");

      // R8/R9: fill, lose one, deferred overrun flag
      for (int i = 0; i < 16; i++) send_frame(8'(8'h40 + i), 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      check(level == 16, "R7 full level", level, 16);
      check(rts_n == 1'b1, "R10 rts_n high when full", rts_n, 1);
      rts_en = 1'b0;
      @(negedge clk);
      check(rts_n == 1'b0, "R10 rts_n low when disabled", rts_n, 0);
      rts_en = 1'b1;
      send_frame(8'hEE, 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      check(level == 16, "R8 level stays full", level, 16);
      pop_check("R8 oldest kept");
      send_frame(8'h77, 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      for (int i = 0; i < 15; i++) pop_check("R8 stored order");
      pop_check("R9 overrun flag on next char");
      send_frame(8'h11, 8, 0, 0, 0, 0, 1'b1, BIT_CLKS);
      pop_check("R9 overrun flag cleared");
      check(level == 0, "R7 empty at end", level, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule